// File: doc/BRIEF.md
# CAN Interrupt Source Indicator

This block condenses the interrupt sources of a CAN controller with fifteen message centers into one read-only byte. The byte names the single most urgent pending source. Sources are a status-change event and, for each center, a completed transmission or a reception whose data was stored into that center. Each event sets a sticky pending flag. A flag stays set until software strobes the matching clear input.

A pending flag is only reported while its own source enable is set. The byte ignores the global and peripheral interrupt enables, so software can poll it with CPU interrupts masked. Those two enables only gate the interrupt request line. The byte is driven combinationally from the registered flags and the live enables, so it serves directly as the read data of a simple register read port.

Top module: `can_irq_indicator`

## Requirements
- R1: During and after reset, with no enabled source pending, `ind_o` reads 00h and `irq_o` is low.
- R2: A pending status change reads as 01h when `stat_ie_a_i` or `stat_ie_b_i` (either one) is set. With both clear, it is not reported.
- R3: A pending center n reads as 02h when n = 15, and as 02h + n for n = 1 to 14. Center n maps to bit n-1 of every per-center vector.
- R4: A completed transmit (`tx_done_i`) is reported only while that center's `tx_ie_i` bit is set. A stored reception (`rx_stored_i`) is reported only while that center's `rx_ie_i` bit is set.
- R5: With several sources reported, the one shown is chosen by fixed priority: status change first, then center 15, then centers 1 to 14 in ascending order.
- R6: Pending flags are sticky. A one-cycle event keeps its source pending in later cycles. A flag set while its enable is clear is shown as soon as the enable is set.
- R7: A clear strobe (`stat_clr_i` or a `mc_clr_i` bit) removes that source from the clock edge it is sampled on. The byte then shows the next pending source, or 00h. If an event and its clear arrive in the same cycle, the event wins.
- R8: `ind_o` does not depend on `glb_ie_i` or `per_ie_i`.
- R9: `irq_o` is high exactly when `ind_o` is non-zero and both `glb_ie_i` and `per_ie_i` are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stat_evt_i | input | 1 | Status-change event pulse |
| stat_ie_a_i | input | 1 | First status interrupt enable |
| stat_ie_b_i | input | 1 | Second status interrupt enable |
| stat_clr_i | input | 1 | Clears the pending status change |
| tx_done_i | input | 15 | Per-center transmit-complete pulses |
| rx_stored_i | input | 15 | Per-center receive-and-store pulses |
| tx_ie_i | input | 15 | Per-center transmit interrupt enables |
| rx_ie_i | input | 15 | Per-center receive interrupt enables |
| mc_clr_i | input | 15 | Per-center clear strobes (clear both transmit and receive flags) |
| glb_ie_i | input | 1 | Global interrupt enable |
| per_ie_i | input | 1 | CAN peripheral interrupt enable |
| ind_o | output | 8 | Encoded indicator byte |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench targets the non-linear mapping of center 15 to 02h. An encoder that counted linearly would report 11h, or would place center 15 behind center 1. It drives an event and its clear in the same cycle: a design that let the clear win would drop an interrupt and read one code too far down the chain. It also sets flags while their enables are off and then raises the enables. A design that gated the event instead of the report would lose those sources. Finally, it toggles the global and peripheral enables under a pending source to catch an indicator that wrongly reads zero while CPU interrupts are masked.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int IND_W = 8;
  typedef logic [IND_W-1:0] ind_t;
  localparam ind_t IND_NONE = 8'h00;
  localparam ind_t IND_STAT = 8'h01;
  localparam ind_t IND_TOP  = 8'h02;  // highest-numbered center
endpackage

// File: rtl/can_irq_flags.sv
module can_irq_flags #(
  parameter int N_MC = 15
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            stat_evt_i,
  input  logic            stat_clr_i,
  input  logic [N_MC-1:0] tx_done_i,
  input  logic [N_MC-1:0] rx_stored_i,
  input  logic [N_MC-1:0] mc_clr_i,
  output logic            stat_pend_o,
  output logic [N_MC-1:0] tx_pend_o,
  output logic [N_MC-1:0] rx_pend_o
);

  // set wins over clear so an event is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         stat_pend_o <= 1'b0;
    else if (stat_evt_i) stat_pend_o <= 1'b1;
    else if (stat_clr_i) stat_pend_o <= 1'b0;
  end

  for (genvar g = 0; g < N_MC; g++) begin : g_mc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tx_pend_o[g] <= 1'b0;
        rx_pend_o[g] <= 1'b0;
      end else begin
        if (tx_done_i[g])     tx_pend_o[g] <= 1'b1;
        else if (mc_clr_i[g]) tx_pend_o[g] <= 1'b0;
        if (rx_stored_i[g])   rx_pend_o[g] <= 1'b1;
        else if (mc_clr_i[g]) rx_pend_o[g] <= 1'b0;
      end
    end

    p_tx_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tx_done_i[g] |=> tx_pend_o[g]);
    p_rx_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rx_stored_i[g] |=> rx_pend_o[g]);
    p_tx_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tx_pend_o[g] && !mc_clr_i[g]) |=> tx_pend_o[g]);
    p_tx_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mc_clr_i[g] && !tx_done_i[g]) |=> !tx_pend_o[g]);
    p_rx_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mc_clr_i[g] && !rx_stored_i[g]) |=> !rx_pend_o[g]);
  end

  p_stat_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_evt_i |=> stat_pend_o);
  p_stat_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_clr_i && !stat_evt_i) |=> !stat_pend_o);

endmodule

// File: rtl/can_irq_prio.sv
module can_irq_prio
  import can_irq_pkg::*;
#(
  parameter int N_MC = 15
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            stat_act_i,
  input  logic [N_MC-1:0] mc_act_i,
  output ind_t            code_o
);

  // lowest priority first, later assignments override
  always_comb begin
    code_o = IND_NONE;
    for (int i = N_MC - 2; i >= 0; i--) begin
      if (mc_act_i[i]) code_o = IND_W'(i + 3);
    end
    if (mc_act_i[N_MC-1]) code_o = IND_TOP;
    if (stat_act_i)       code_o = IND_STAT;
  end

  p_stat_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_act_i |-> code_o == IND_STAT);
  p_top_center_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_act_i && mc_act_i[N_MC-1]) |-> code_o == IND_TOP);
  p_idle_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_act_i && mc_act_i == '0) |-> code_o == IND_NONE);
  p_code_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_o <= IND_W'(N_MC + 2));

endmodule

// File: rtl/can_irq_indicator.sv
module can_irq_indicator
  import can_irq_pkg::*;
#(
  parameter int N_MC = 15
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            stat_evt_i,
  input  logic            stat_ie_a_i,
  input  logic            stat_ie_b_i,
  input  logic            stat_clr_i,
  input  logic [N_MC-1:0] tx_done_i,
  input  logic [N_MC-1:0] rx_stored_i,
  input  logic [N_MC-1:0] tx_ie_i,
  input  logic [N_MC-1:0] rx_ie_i,
  input  logic [N_MC-1:0] mc_clr_i,
  input  logic            glb_ie_i,
  input  logic            per_ie_i,
  output logic [7:0]      ind_o,
  output logic            irq_o
);

  logic            stat_pend;
  logic [N_MC-1:0] tx_pend, rx_pend;
  logic            stat_act;
  logic [N_MC-1:0] mc_act;
  ind_t            code;

  can_irq_flags #(.N_MC(N_MC)) u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stat_evt_i  (stat_evt_i),
    .stat_clr_i  (stat_clr_i),
    .tx_done_i   (tx_done_i),
    .rx_stored_i (rx_stored_i),
    .mc_clr_i    (mc_clr_i),
    .stat_pend_o (stat_pend),
    .tx_pend_o   (tx_pend),
    .rx_pend_o   (rx_pend)
  );

  // source enables gate the report, not the capture
  assign stat_act = stat_pend & (stat_ie_a_i | stat_ie_b_i);
  assign mc_act   = (tx_pend & tx_ie_i) | (rx_pend & rx_ie_i);

  can_irq_prio #(.N_MC(N_MC)) u_prio (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stat_act_i (stat_act),
    .mc_act_i   (mc_act),
    .code_o     (code)
  );

  assign ind_o = code;
  assign irq_o = (code != IND_NONE) & glb_ie_i & per_ie_i;

  p_irq_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (glb_ie_i && per_ie_i && stat_pend | (|tx_pend) | (|rx_pend)));
  p_stat_shown_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_pend && (stat_ie_a_i || stat_ie_b_i)) |-> ind_o == IND_STAT);

endmodule

// File: tb/sim_can_irq_indicator.sv
module sim_can_irq_indicator;
  localparam int N = 15;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         stat_evt = 0, stat_ie_a = 0, stat_ie_b = 0, stat_clr = 0;
  logic [N-1:0] tx_done = '0, rx_stored = '0, tx_ie = '0, rx_ie = '0, mc_clr = '0;
  logic         glb_ie = 0, per_ie = 0;
  logic [7:0]   ind;
  logic         irq;

  int n_chk = 0, n_fail = 0;

  logic         stat_m = 1'b0;
  logic [N-1:0] tx_m = '0, rx_m = '0;

  always #2 clk = ~clk;

  can_irq_indicator #(.N_MC(N)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .stat_evt_i(stat_evt), .stat_ie_a_i(stat_ie_a), .stat_ie_b_i(stat_ie_b),
    .stat_clr_i(stat_clr), .tx_done_i(tx_done), .rx_stored_i(rx_stored),
    .tx_ie_i(tx_ie), .rx_ie_i(rx_ie), .mc_clr_i(mc_clr),
    .glb_ie_i(glb_ie), .per_ie_i(per_ie), .ind_o(ind), .irq_o(irq)
  );

  function automatic logic [7:0] exp_ind();
    logic [N-1:0] act;
    if (stat_m && (stat_ie_a || stat_ie_b)) return 8'h01;
    act = (tx_m & tx_ie) | (rx_m & rx_ie);
    if (act[N-1]) return 8'h02;
    for (int c = 1; c < N; c++) if (act[c-1]) return 8'(2 + c);
    return 8'h00;
  endfunction

  task automatic chk(input string tag);
    logic [7:0] e;
    logic       ei;
    e  = exp_ind();
    ei = (e != 0) && glb_ie && per_ie;
    n_chk++;
    if (ind !== e) begin
      n_fail++;
      $display("FAIL %s ind actual=%02h expected=%02h", tag, ind, e);
    end
    n_chk++;
    if (irq !== ei) begin
      n_fail++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, ei);
    end
  endtask

  // one clock: model follows held inputs, then check, then drop pulses
  task automatic cyc(input string tag);
    @(posedge clk);
    stat_m = stat_evt | (stat_m & ~stat_clr);
    tx_m   = tx_done | (tx_m & ~mc_clr);
    rx_m   = rx_stored | (rx_m & ~mc_clr);
    #1;
    chk(tag);
    stat_evt = 0; stat_clr = 0; tx_done = '0; rx_stored = '0; mc_clr = '0;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    // R1: reset holds byte at zero even with events and enables present
    stat_evt = 1; stat_ie_a = 1; tx_done = '1; tx_ie = '1; glb_ie = 1; per_ie = 1;
    repeat (3) @(posedge clk);
    #1 chk("R1");
    @(negedge clk);
    stat_evt = 0; tx_done = '0; tx_ie = '0; stat_ie_a = 0;
    rst_ni = 1;
    cyc("R1");

    // R2: either status enable
    stat_evt = 1; stat_ie_a = 1; cyc("R2");
    stat_ie_a = 0; stat_ie_b = 1; #1 chk("R2");
    stat_ie_b = 0; #1 chk("R2");
    stat_clr = 1; cyc("R7");

    // R3: every center code, one at a time
    tx_ie = '1;
    for (int c = 1; c <= N; c++) begin
      tx_done[c-1] = 1'b1; cyc("R3");
      mc_clr[c-1] = 1'b1; cyc("R7");
    end

    // R4: transmit vs receive enables
    tx_ie = '0; rx_ie = '0;
    tx_done[2] = 1; cyc("R4");
    rx_stored[5] = 1; cyc("R4");
    rx_ie[5] = 1; #1 chk("R4");
    tx_ie[2] = 1; #1 chk("R4");
    rx_ie = '0; tx_ie = '0; #1 chk("R4");
    // R6: latched while disabled, shown on enable
    cyc("R6");
    tx_ie = '1; rx_ie = '1; #1 chk("R6");
    mc_clr = '1; cyc("R7");

    // R5: priority chain drained by clears
    stat_ie_a = 1; stat_evt = 1; tx_done = '1; cyc("R5");
    stat_clr = 1; cyc("R5");
    mc_clr[N-1] = 1; cyc("R5");
    for (int c = 1; c < N; c++) begin
      mc_clr[c-1] = 1; cyc("R5");
    end

    // R7: event and clear in the same cycle, event wins
    tx_done[3] = 1; mc_clr[3] = 1; cyc("R7");
    cyc("R7");
    mc_clr[3] = 1; cyc("R7");

    // R8/R9: CPU enables leave byte unchanged
    rx_stored[9] = 1; cyc("R8");
    for (int k = 0; k < 4; k++) begin
      glb_ie = k[0]; per_ie = k[1]; #1 chk("R8");
      chk("R9");
    end
    mc_clr = '1; cyc("R9");

    // random traffic
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      stat_evt  = ($urandom % 16) == 0;
      stat_clr  = ($urandom % 6) == 0;
      stat_ie_a = ($urandom % 3) == 0;
      stat_ie_b = ($urandom % 3) == 0;
      tx_done   = N'($urandom & $urandom & $urandom);
      rx_stored = N'($urandom & $urandom & $urandom);
      mc_clr    = N'($urandom & $urandom);
      tx_ie     = N'($urandom);
      rx_ie     = N'($urandom);
      glb_ie    = $urandom % 2;
      per_ie    = $urandom % 2;
      cyc("R5");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule